// File: doc/BRIEF.md
# Per-Bit Condition Trigger with Glitch Filter and Post-Trigger Delay

This block watches a stream of sampled input vectors and raises a trigger when every bit satisfies its own programmed condition. Each bit can be told to need a high level, a low level, a rising edge, a falling edge, or nothing at all. Edges are judged against the previous strobed sample, so any number of bits may carry edge conditions at once, and all of them must see their edge in the same sample.

A glitch filter stands between the raw comparison and the trigger. The full-vector match must hold over a programmed number of consecutive samples before the trigger is accepted, and one mismatching sample starts the count again. Once the trigger is accepted, a delay counter counts a further programmed number of samples and then raises a capture-stop signal. A capture engine uses this to place the trigger anywhere in its record. A fixed-length pulse is driven out at the moment of the trigger so that outside instruments can start as well. The unit is armed by a one-cycle command and fires at most once per arming.

Top module: `trg_unit`

## Requirements
- R1: After synchronous reset, and until the first arm command, match_raw, trig_hit, cap_stop and trig_out are all low, whatever samples arrive.
- R2: Bit i's condition is cond_code[3i+2:3i]. 0 means don't care, 1 means high, 2 means low, 3 means rising and 4 means falling. Codes 5 to 7 act as don't care. While the unit is armed, match_raw is registered on each strobed sample and shows whether all bits met their condition. It holds its value between strobes and is low in every other state, except during the cycle right after the trigger sample.
- R3: A rising (or falling) condition is met only when the bit was 0 (or 1) in the previous strobed sample since arming and is 1 (or 0) now. On the first strobed sample after arming, every edge condition is unmet.
- R4: Several bits may carry edge conditions at the same time. The vector matches only when each of them sees its own edge in the same sample.
- R5: trig_hit rises on the clock edge of the strobed sample that completes filt_len+1 consecutive matching samples. A non-matching sample restarts the count. With filt_len=0, the first matching sample triggers.
- R6: Once set, trig_hit stays high until the next arm command. The unit does not trigger again within one arming.
- R7: cap_stop rises on the clock edge of the dly_len-th strobed sample after the trigger sample. With dly_len=0 it rises together with trig_hit. It then stays high until the next arm command.
- R8: trig_out is high for exactly PULSE_LEN clock cycles, starting in the cycle in which trig_hit first reads high.
- R9: Cycles with smp_vld low leave the outputs and the filter and delay counts unchanged, apart from trig_out counting down.
- R10: An arm command in any state, including during the delay, clears all outputs and restarts comparison. A sample strobed in the same cycle as arm is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle command that arms and restarts the unit |
| smp_vld | input | 1 | Strobe marking smp_data as a new sample |
| smp_data | input | WIDTH | Sampled input vector |
| cond_code | input | 3*WIDTH | Three-bit condition code for each bit |
| filt_len | input | FILT_W | Extra consecutive matching samples required |
| dly_len | input | DLY_W | Samples from trigger to capture stop |
| match_raw | output | 1 | Registered full-vector match of the last sample |
| trig_hit | output | 1 | Filtered trigger, held until re-arm |
| cap_stop | output | 1 | Capture must stop, held until re-arm |
| trig_out | output | 1 | Fixed-length external trigger pulse |

## Verification
Directed cases set one condition type at a time: level-only vectors, a single rising edge whose first sample after arming must not match, and two simultaneous opposite edges where one missing edge must block the match. These separate level decoding from edge history. Filter runs broken by one mismatching sample check whether the count truly restarts, and filt_len and dly_len of zero check the same-edge corner cases. Random condition mixes with sparse strobes and re-arms mid-delay then compare every output, cycle by cycle, against a bench model of the requirements.

// File: rtl/trg_pkg.sv
package trg_pkg;

    typedef enum logic [2:0] {
        CC_ANY  = 3'd0,
        CC_HIGH = 3'd1,
        CC_LOW  = 3'd2,
        CC_RISE = 3'd3,
        CC_FALL = 3'd4
    } cond_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_POST  = 2'd2,
        ST_DONE  = 2'd3
    } state_e;

    typedef struct packed {
        logic hit;
        logic stop;
        logic pulse;
    } trg_flags_t;

    // One bit against its condition; unknown codes behave as don't care.
    function automatic logic bit_ok(input logic [2:0] code, input logic cur,
                                    input logic prev, input logic hist);
        logic r;
        case (code)
            CC_HIGH: r = cur;
            CC_LOW:  r = !cur;
            CC_RISE: r = hist && !prev && cur;
            CC_FALL: r = hist && prev && !cur;
            default: r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/trg_match.sv
module trg_match #(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               en,
    input  logic [WIDTH-1:0]   data,
    input  logic [3*WIDTH-1:0] codes,
    output logic               all_ok
);
    import trg_pkg::*;

    logic [WIDTH-1:0] prev_q;
    logic             hist_q;
    logic [WIDTH-1:0] ok;

    // Previous-sample history used by the edge conditions.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            prev_q <= '0;
            hist_q <= 1'b0;
        end else if (en) begin
            prev_q <= data;
            hist_q <= 1'b1;
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign ok[i] = bit_ok(codes[3*i +: 3], data[i], prev_q[i], hist_q);
    end

    assign all_ok = &ok;

endmodule

// File: rtl/trg_filter.sv
module trg_filter #(
    parameter int FILT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic              hit_in,
    input  logic [FILT_W-1:0] filt_len,
    output logic              fire
);
    logic [FILT_W-1:0] run_q;

    assign fire = en && hit_in && (run_q == filt_len);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            run_q <= '0;
        end else if (en) begin
            if (!hit_in)
                run_q <= '0;
            else if (run_q != filt_len)
                run_q <= run_q + 1'b1;
        end
    end

    AST_RUN_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (en && !hit_in && !clr) |=> (run_q == '0)) else $error("run count kept"); // R5

endmodule

// File: rtl/trg_delay.sv
module trg_delay #(
    parameter int DLY_W     = 16,
    parameter int PULSE_LEN = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                start,
    input  logic                vld,
    input  logic [DLY_W-1:0]    dly_len,
    output trg_pkg::trg_flags_t flags
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    logic             hit_q, stop_q, active_q;
    logic [DLY_W-1:0] dcnt_q;
    logic [PW-1:0]    pcnt_q;
    logic [DLY_W:0]   dnext;

    assign dnext = {1'b0, dcnt_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hit_q    <= 1'b0;
            stop_q   <= 1'b0;
            active_q <= 1'b0;
            dcnt_q   <= '0;
            pcnt_q   <= '0;
        end else if (start) begin
            hit_q  <= 1'b1;
            pcnt_q <= PW'(PULSE_LEN);
            dcnt_q <= '0;
            if (dly_len == '0)
                stop_q <= 1'b1;
            else
                active_q <= 1'b1;
        end else begin
            if (pcnt_q != '0)
                pcnt_q <= pcnt_q - 1'b1;
            if (active_q && vld) begin
                if (dnext == {1'b0, dly_len}) begin
                    stop_q   <= 1'b1;
                    active_q <= 1'b0;
                end else begin
                    dcnt_q <= dnext[DLY_W-1:0];
                end
            end
        end
    end

    assign flags.hit   = hit_q;
    assign flags.stop  = stop_q;
    assign flags.pulse = (pcnt_q != '0);

    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (rst)
        pcnt_q <= PW'(PULSE_LEN)) else $error("pulse counter out of range"); // R8
    AST_STOP_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (active_q && stop_q) == 1'b0) else $error("delay still running after stop"); // R7

endmodule

// File: rtl/trg_unit.sv
module trg_unit #(
    parameter int WIDTH     = 16,
    parameter int FILT_W    = 8,
    parameter int DLY_W     = 16,
    parameter int PULSE_LEN = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               arm,
    input  logic               smp_vld,
    input  logic [WIDTH-1:0]   smp_data,
    input  logic [3*WIDTH-1:0] cond_code,
    input  logic [FILT_W-1:0]  filt_len,
    input  logic [DLY_W-1:0]   dly_len,
    output logic               match_raw,
    output logic               trig_hit,
    output logic               cap_stop,
    output logic               trig_out
);
    import trg_pkg::*;

    state_e     state_q;
    logic       cmp_en;
    logic       vec_ok;
    logic       fire;
    logic       match_q;
    trg_flags_t flags;

    // A sample arriving together with arm is dropped.
    assign cmp_en = (state_q == ST_ARMED) && smp_vld && !arm;

    trg_match #(.WIDTH(WIDTH)) u_match (
        .clk(clk), .rst(rst), .clr(arm), .en(cmp_en),
        .data(smp_data), .codes(cond_code), .all_ok(vec_ok)
    );

    trg_filter #(.FILT_W(FILT_W)) u_filter (
        .clk(clk), .rst(rst), .clr(arm), .en(cmp_en),
        .hit_in(vec_ok), .filt_len(filt_len), .fire(fire)
    );

    trg_delay #(.DLY_W(DLY_W), .PULSE_LEN(PULSE_LEN)) u_delay (
        .clk(clk), .rst(rst), .clr(arm), .start(fire),
        .vld(smp_vld), .dly_len(dly_len), .flags(flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else if (arm) begin
            state_q <= ST_ARMED;
        end else begin
            case (state_q)
                ST_ARMED: if (fire)       state_q <= ST_POST;
                ST_POST:  if (flags.stop) state_q <= ST_DONE;
                default:  state_q <= state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || arm)
            match_q <= 1'b0;
        else if (cmp_en)
            match_q <= vec_ok;
        else if (state_q != ST_ARMED)
            match_q <= 1'b0;
    end

    assign match_raw = match_q;
    assign trig_hit  = flags.hit;
    assign cap_stop  = flags.stop;
    assign trig_out  = flags.pulse;

    AST_ROSE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
        $rose(trig_hit) |-> match_raw) else $error("trigger without match"); // R5
    AST_HIT_HELD: assert property (@(posedge clk) disable iff (rst)
        (trig_hit && !arm) |=> trig_hit) else $error("trigger dropped"); // R6
    AST_STOP_AFTER_HIT: assert property (@(posedge clk) disable iff (rst)
        cap_stop |-> trig_hit) else $error("stop without trigger"); // R7
    AST_PULSE_WITH_HIT: assert property (@(posedge clk) disable iff (rst)
        $rose(trig_hit) |-> trig_out) else $error("no pulse at trigger"); // R8
    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!smp_vld && !arm && state_q == ST_ARMED) |=> $stable(match_raw))
        else $error("match moved without strobe"); // R9
    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
        arm |=> (!trig_hit && !cap_stop && !match_raw)) else $error("arm did not clear"); // R10

endmodule

// File: tb/sim_trg_unit.sv
module sim_trg_unit;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int FW = 4;
    localparam int DW = 6;
    localparam int PL = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            arm = 1'b0;
    logic            vld = 1'b0;
    logic [W-1:0]    data = '0;
    logic [3*W-1:0]  cond = '0;
    logic [FW-1:0]   filt = '0;
    logic [DW-1:0]   dly = '0;
    logic            match_raw, trig_hit, cap_stop, trig_out;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    // bench model state: 0 idle, 1 armed, 2 post, 3 done
    int            m_st = 0;
    logic [W-1:0]  m_prev = '0;
    bit            m_hist = 0;
    int            m_run = 0, m_dcnt = 0, m_pcnt = 0;
    bit            m_match = 0, m_hit = 0, m_stop = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trg_unit #(.WIDTH(W), .FILT_W(FW), .DLY_W(DW), .PULSE_LEN(PL)) u0 (
        .clk(clk), .rst(rst), .arm(arm), .smp_vld(vld), .smp_data(data),
        .cond_code(cond), .filt_len(filt), .dly_len(dly),
        .match_raw(match_raw), .trig_hit(trig_hit),
        .cap_stop(cap_stop), .trig_out(trig_out)
    );

    function automatic bit exp_bit(input int code, input bit cur, input bit prv, input bit hist);
        case (code)
            1: return cur;
            2: return !cur;
            3: return hist && !prv && cur;
            4: return hist && prv && !cur;
            default: return 1'b1;
        endcase
    endfunction

    function automatic bit exp_vec(input logic [W-1:0] d);
        bit r = 1'b1;
        for (int i = 0; i < W; i++)
            if (!exp_bit(int'(cond[3*i +: 3]), d[i], m_prev[i], m_hist)) r = 1'b0;
        return r;
    endfunction

    task automatic chk(input bit got, input bit exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%0b expected=%0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        chk(match_raw, m_match, {tag, " R2 match_raw"});
        chk(trig_hit,  m_hit,   {tag, " R5 trig_hit"});
        chk(cap_stop,  m_stop,  {tag, " R7 cap_stop"});
        chk(trig_out,  m_pcnt != 0, {tag, " R8 trig_out"});
    endtask

    // model one clock edge for a cycle without arm
    task automatic model_edge(input bit v, input logic [W-1:0] d);
        bit fired = 0;
        bit ok;
        if (m_st == 1 && v) begin
            ok = exp_vec(d);
            m_match = ok;
            if (ok) begin
                if (m_run == int'(filt)) fired = 1;
                else m_run++;
            end else m_run = 0;
            m_prev = d;
            m_hist = 1;
        end else if (m_st != 1) begin
            m_match = 0;
        end
        if (fired) begin
            m_hit = 1; m_pcnt = PL; m_dcnt = 0;
            if (dly == 0) begin m_stop = 1; m_st = 3; end
            else m_st = 2;
        end else begin
            if (m_pcnt > 0) m_pcnt--;
            if (m_st == 2 && v) begin
                if (m_dcnt + 1 == int'(dly)) begin m_stop = 1; m_st = 3; end
                else m_dcnt++;
            end
        end
    endtask

    task automatic step(input bit v, input logic [W-1:0] d, input string tag);
        @(negedge clk);
        vld = v; data = d; arm = 1'b0;
        @(posedge clk);
        model_edge(v, d);
        #1 check_all(tag);
    endtask

    task automatic do_arm(input bit v, input logic [W-1:0] d, input string tag);
        @(negedge clk);
        arm = 1'b1; vld = v; data = d;
        @(posedge clk);
        m_st = 1; m_prev = '0; m_hist = 0; m_run = 0; m_dcnt = 0;
        m_pcnt = 0; m_match = 0; m_hit = 0; m_stop = 0;
        #1 check_all({tag, " R10"});
        @(negedge clk);
        arm = 1'b0; vld = 1'b0;
    endtask

    function automatic logic [3*W-1:0] all_code(input logic [2:0] c);
        logic [3*W-1:0] r;
        for (int i = 0; i < W; i++) r[3*i +: 3] = c;
        return r;
    endfunction

    task automatic set_code(input int bitno, input logic [2:0] c);
        @(negedge clk);
        cond[3*bitno +: 3] = c;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL R1 watchdog: got=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1 check_all("reset R1");
        // samples before arm are ignored (R1)
        step(1, 8'hFF, "prearm R1");
        step(1, 8'h00, "prearm R1");

        // all don't care, no filter, no delay: first strobe fires (R5, R7)
        cond = all_code(3'd0); filt = 0; dly = 0;
        do_arm(1, 8'h55, "dc");
        step(0, 8'h00, "dc no strobe R9");
        step(1, 8'h12, "dc fire R5 R7");
        for (int k = 0; k < 5; k++) step(1, 8'h00, "dc after R6 R8");

        // levels: bit0 high, bit1 low, unknown code 7 on bit2 (R2)
        cond = all_code(3'd0); cond[2:0] = 3'd1; cond[5:3] = 3'd2; cond[8:6] = 3'd7;
        filt = 2; dly = 3;
        do_arm(0, 8'h00, "lvl");
        step(1, 8'h02, "lvl miss R2");
        step(1, 8'h05, "lvl hit1 R2");
        step(1, 8'h01, "lvl hit2 R5");
        step(1, 8'h03, "lvl glitch R5");
        step(0, 8'h00, "lvl idle R9");
        step(1, 8'h01, "lvl h1 R5");
        step(1, 8'h01, "lvl h2 R5");
        step(1, 8'h01, "lvl h3 fire R5");
        step(0, 8'h00, "lvl gap R9");
        for (int k = 0; k < 5; k++) step(k % 2 == 0, 8'h00, "lvl delay R7");

        // rising edge on bit 3; first sample after arm must not match (R3)
        cond = all_code(3'd0); cond[11:9] = 3'd3; filt = 0; dly = 2;
        do_arm(1, 8'h08, "rise same-cycle R10");
        step(1, 8'h08, "rise first R3");
        step(1, 8'h00, "rise low R3");
        step(1, 8'h08, "rise edge R3");
        for (int k = 0; k < 4; k++) step(1, 8'h00, "rise post R7");

        // two opposite edges at once (R4)
        cond = all_code(3'd0); cond[2:0] = 3'd3; cond[23:21] = 3'd4; filt = 0; dly = 5;
        do_arm(0, 8'h00, "two");
        step(1, 8'h80, "two init R4");
        step(1, 8'h81, "two only rise R4");
        step(1, 8'h80, "two reset R4");
        step(1, 8'h00, "two only fall R4");
        step(1, 8'h80, "two setup R4");
        step(1, 8'h01, "two both R4");
        step(1, 8'h00, "two post R7");
        // re-arm in the middle of the delay (R10)
        do_arm(0, 8'h00, "rearm mid R10");
        step(1, 8'h80, "rearm again R4");
        step(1, 8'h01, "rearm fire R6");

        // random mix
        for (int r = 0; r < 40; r++) begin
            for (int i = 0; i < W; i++) begin
                int c = $urandom % 16;
                cond[3*i +: 3] = (c < 9) ? 3'd0 : 3'(c % 8);
            end
            filt = FW'($urandom % 3);
            dly  = DW'($urandom % 5);
            do_arm($urandom % 2, W'($urandom), "rnd R10");
            for (int k = 0; k < 30; k++) begin
                logic [W-1:0] d = W'($urandom);
                if ($urandom % 3 == 0) d = m_prev;
                step($urandom % 4 != 0, d, "rnd R2 R3 R5");
            end
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule